// File: doc/BRIEF.md
# Skip-Scan Text Position Controller

This block steers a sub-linear multi-pattern scan over a text buffer. It holds the byte address of the block of `BLK` bytes under examination, the suffix of a search window of `win_size` bytes. Each cycle it reads a vector of group hits for that block, one bit per position group. Group `g` holds the pattern blocks that end `g` bytes before the end of a window. From that vector it decides where to fetch next. The filters that produce the hit vector sit outside the block.

A miss in every group moves the window by the largest safe distance. A hit in group `g` moves the window so that the block lines up with the place it occurs. When the suffix block hits group 0, the controller does not hand the window to verification at once. It walks back one byte per cycle and tests each earlier block against its own group. On the first mismatch it moves the window forward by a bad-character distance. Only a window whose blocks hit all their groups becomes a verification job. The job carries the window start address and the window length, and the controller waits while the job buffer reports full. The scan stops and raises `done` when the next suffix block would run past the end of the text.

Top module: `skipscan_pos_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `fetch_addr` is 0, `job_req` is 0 and `done` is 0. The controller is idle.
- R2: A `start` seen while idle sets `fetch_addr` to `win_size - BLK` on the next cycle and clears `done`. While a scan is in progress, `start` is ignored.
- R3: During a normal scan, let `i` be the lowest hit group in 0..`win_size-BLK`. The shift is `i`, or `win_size-BLK+1` when no group in that range hits. A nonzero shift is added to `fetch_addr` on the next cycle.
- R4: A zero shift saves the current address as the anchor. `fetch_addr` then drops by one per cycle. At `j` bytes back, the block is tested against group `j`, for `j = 1, 2, ...`.
- R5: If the block `j` bytes back misses group `j`, let `i` be the lowest hit group with `j < i <= win_size-BLK`. The distance `d` is `i - j`, or `win_size-BLK+1-j` when there is none. The next address is anchor + `d`. One cycle follows in which the hit vector is ignored, and then normal scanning resumes.
- R6: When the block `win_size-BLK` bytes back also hits, `job_req` pulses for exactly one cycle with `job_anchor` = anchor - `win_size` + `BLK` and `job_len` = `win_size`. Scanning resumes at anchor + 1 after one ignored cycle. With `win_size = BLK`, the job follows the group-0 hit one cycle later.
- R7: If `job_full` is high when a job becomes due, `fetch_addr` holds and no job is issued. The job is issued on the cycle after `job_full` is sampled low.
- R8: When the next address plus `BLK` would exceed `text_len`, `done` rises instead and stays high until the next accepted `start`.
- R9: Hit bits above index `win_size-BLK` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (accepted only when idle) |
| text_len | input | AW | Number of bytes in the text |
| win_size | input | WW | Search window length (BLK..NGRP+BLK-1) |
| grp_hit | input | NGRP | Group hit vector for the block at `fetch_addr` |
| job_full | input | 1 | Verification job buffer has no free slot |
| fetch_addr | output | AW | Byte address of the block being examined |
| job_req | output | 1 | One-cycle verification job request |
| job_anchor | output | AW | Start address of the window to verify |
| job_len | output | WW | Length of the window to verify |
| done | output | 1 | Scan finished |

## Verification
The bench uses BLK = 4, NGRP = 8 and a 12-bit address. This allows window lengths from 4 up to 11. It covers the degenerate single-group case, mid-size windows where the back-walk runs several steps, and the widest window where distances reach 8. The hit vector is derived from a real text and pattern set, so hits, partial matches and full matches arise from the data. Texts made only of repeated bytes force a job at every position, and a pseudo-random full flag holds those jobs. A text shorter than one window reaches the immediate-finish case. Setting the unused high hit bits shows that they have no effect.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [2:0] {
    ST_INIT   = 3'd0,
    ST_SHIFT  = 3'd1,
    ST_CHECK  = 3'd2,
    ST_RESUME = 3'd3,
    ST_STALL  = 3'd4
  } pc_state_e;
endpackage

// File: rtl/pc_first_hit.sv
module pc_first_hit #(
  parameter int N  = 8,
  parameter int GW = 4
) (
  input  logic [N-1:0]  hit,
  input  logic [GW-1:0] lo,
  input  logic [GW-1:0] hi,
  output logic          found,
  output logic [GW-1:0] idx
);
  // lowest set bit inside [lo, hi]; scan from the top so the lowest wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i] && (GW'(i) >= lo) && (GW'(i) <= hi)) begin
        found = 1'b1;
        idx   = GW'(i);
      end
    end
  end
endmodule

// File: rtl/pc_end_detect.sv
module pc_end_detect #(
  parameter int AW  = 12,
  parameter int BLK = 4
) (
  input  logic [AW:0]   nxt,
  input  logic [AW-1:0] text_len,
  output logic          past_end
);
  logic [AW+1:0] blk_end;
  assign blk_end  = {1'b0, nxt} + (AW+2)'(BLK);
  assign past_end = blk_end > {2'b00, text_len};
endmodule

// File: rtl/skipscan_pos_ctrl.sv
module skipscan_pos_ctrl
  import pc_pkg::*;
#(
  parameter int BLK  = 4,
  parameter int NGRP = 8,
  parameter int AW   = 12,
  parameter int WW   = $clog2(NGRP + BLK)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   text_len,
  input  logic [WW-1:0]   win_size,
  input  logic [NGRP-1:0] grp_hit,
  input  logic            job_full,
  output logic [AW-1:0]   fetch_addr,
  output logic            job_req,
  output logic [AW-1:0]   job_anchor,
  output logic [WW-1:0]   job_len,
  output logic            done
);
  localparam int GW = $clog2(NGRP + 1);

  pc_state_e     state_q;
  logic [AW-1:0] pos_q, save_q;
  logic [GW-1:0] j_q;

  // highest group index that is meaningful for this window
  logic [WW:0]   last_w;
  logic [GW-1:0] last_g;
  assign last_w = {1'b0, win_size} - (WW+1)'(BLK);
  assign last_g = GW'(last_w);

  logic [GW-1:0] lo_g;
  logic          fh_found;
  logic [GW-1:0] fh_idx;
  assign lo_g = (state_q == ST_CHECK) ? j_q + GW'(1) : '0;

  pc_first_hit #(.N(NGRP), .GW(GW)) u_first (
    .hit  (grp_hit),
    .lo   (lo_g),
    .hi   (last_g),
    .found(fh_found),
    .idx  (fh_idx)
  );

  logic          hit_j;
  logic [GW-1:0] shift_g, dist_g;
  logic          all_hit;
  assign hit_j   = |(grp_hit & (NGRP'(1) << j_q));
  assign shift_g = fh_found ? fh_idx : last_g + GW'(1);
  assign dist_g  = fh_found ? (fh_idx - j_q) : (last_g + GW'(1) - j_q);
  assign all_hit = hit_j && (j_q == last_g);

  logic [AW:0] nxt;
  logic        past_end;
  always_comb begin
    unique case (state_q)
      ST_INIT:  nxt = (AW+1)'(last_g);
      ST_SHIFT: nxt = {1'b0, pos_q} + (AW+1)'(shift_g);
      ST_CHECK: nxt = all_hit ? {1'b0, save_q} + (AW+1)'(1)
                              : {1'b0, save_q} + (AW+1)'(dist_g);
      default:  nxt = {1'b0, save_q} + (AW+1)'(1);
    endcase
  end

  pc_end_detect #(.AW(AW), .BLK(BLK)) u_end (
    .nxt     (nxt),
    .text_len(text_len),
    .past_end(past_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_INIT;
      pos_q      <= '0;
      save_q     <= '0;
      j_q        <= '0;
      job_req    <= 1'b0;
      job_anchor <= '0;
      job_len    <= '0;
      done       <= 1'b0;
    end else begin
      job_req <= 1'b0;
      unique case (state_q)
        ST_INIT: begin
          if (start) begin
            pos_q <= nxt[AW-1:0];
            done  <= past_end;
            if (!past_end) state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (shift_g == '0) begin
            save_q <= pos_q;
            if (last_g == '0) begin
              state_q <= ST_STALL;
            end else begin
              pos_q   <= pos_q - AW'(1);
              j_q     <= GW'(1);
              state_q <= ST_CHECK;
            end
          end else if (past_end) begin
            done    <= 1'b1;
            state_q <= ST_INIT;
          end else begin
            pos_q <= nxt[AW-1:0];
          end
        end
        ST_CHECK: begin
          if (all_hit && job_full) begin
            state_q <= ST_STALL;
          end else if (hit_j && !all_hit) begin
            pos_q <= pos_q - AW'(1);
            j_q   <= j_q + GW'(1);
          end else begin
            if (all_hit) begin
              job_req    <= 1'b1;
              job_anchor <= save_q - AW'(last_g);
              job_len    <= win_size;
            end
            if (past_end) begin
              done    <= 1'b1;
              state_q <= ST_INIT;
            end else begin
              pos_q   <= nxt[AW-1:0];
              state_q <= ST_RESUME;
            end
          end
        end
        ST_STALL: begin
          if (!job_full) begin
            job_req    <= 1'b1;
            job_anchor <= save_q - AW'(last_g);
            job_len    <= win_size;
            if (past_end) begin
              done    <= 1'b1;
              state_q <= ST_INIT;
            end else begin
              pos_q   <= nxt[AW-1:0];
              state_q <= ST_RESUME;
            end
          end
        end
        default: state_q <= ST_SHIFT;
      endcase
    end
  end

  assign fetch_addr = pos_q;

  // R4
  walk_align_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CHECK) |-> (({1'b0, pos_q} + (AW+1)'(j_q)) == {1'b0, save_q}) && (j_q != '0));
  // R7
  job_slot_chk: assert property (@(posedge clk) disable iff (rst)
    job_req |-> $past(!job_full));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STALL && job_full) |=> $stable(pos_q));
  // R6
  job_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    job_req |=> !job_req);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (state_q == ST_INIT));
endmodule

// File: tb/tb_skipscan_pos_ctrl.sv
module tb_skipscan_pos_ctrl;
  localparam int BLK = 4;
  localparam int NG  = 8;
  localparam int AW  = 12;
  localparam int WW  = $clog2(NG + BLK);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] text_len = '0;
  logic [WW-1:0] win_size = WW'(8);
  logic [NG-1:0] grp_hit;
  logic job_full = 1'b0;
  logic [AW-1:0] fetch_addr, job_anchor;
  logic job_req, done;
  logic [WW-1:0] job_len;

  always #10 clk = ~clk;

  skipscan_pos_ctrl #(.BLK(BLK), .NGRP(NG), .AW(AW)) dut (
    .clk(clk), .rst(rst), .start(start), .text_len(text_len),
    .win_size(win_size), .grp_hit(grp_hit), .job_full(job_full),
    .fetch_addr(fetch_addr), .job_req(job_req), .job_anchor(job_anchor),
    .job_len(job_len), .done(done));

  byte txt [256];
  byte pat [2][12];
  int  npat = 1;
  bit  junk = 0;
  bit  full_mode = 0;
  int  vec = 0, miss = 0;
  int  jobs = 0, last_anchor = -1;

  function automatic logic [NG-1:0] calc_hit(int a);
    logic [NG-1:0] h = '0;
    int m = int'(win_size);
    for (int g = 0; g <= m - BLK; g++) begin
      for (int p = 0; p < npat; p++) begin
        bit ok = 1;
        for (int k = 0; k < BLK; k++)
          if (a + k > 255 || txt[a + k] != pat[p][m - BLK - g + k]) ok = 0;
        if (ok) h[g] = 1'b1;
      end
    end
    if (junk) for (int g = m - BLK + 1; g < NG; g++) h[g] = 1'b1;
    return h;
  endfunction

  assign grp_hit = calc_hit(int'(fetch_addr));

  // behavioural reference
  int ms = 0, mpos = 0, msave = 0, mj = 0, manc = 0, mlen = 0;
  bit mdone = 0, mjv = 0;
  string tag = "R1";

  function automatic int lowest(int lo, int hi);
    for (int g = lo; g <= hi; g++) if (grp_hit[g]) return g;
    return -1;
  endfunction

  task automatic issue_job(int last);
    int n;
    mjv = 1; manc = msave - last; mlen = int'(win_size);
    n = msave + 1;
    if (n + BLK > int'(text_len)) begin mdone = 1; ms = 0; end
    else begin mpos = n; ms = 3; end
    tag = "R6";
  endtask

  task automatic mstep();
    int last = int'(win_size) - BLK;
    int fi, d, n;
    mjv = 0;
    case (ms)
      0: if (start) begin
           mpos = last; tag = "R2";
           if (last + BLK > int'(text_len)) begin mdone = 1; tag = "R8"; end
           else begin mdone = 0; ms = 1; end
         end
      1: begin
           fi = lowest(0, last);
           d = (fi >= 0) ? fi : last + 1;
           if (d == 0) begin
             msave = mpos; tag = "R4";
             if (last == 0) ms = 4;
             else begin mpos = mpos - 1; mj = 1; ms = 2; end
           end else if (mpos + d + BLK > int'(text_len)) begin
             mdone = 1; ms = 0; tag = "R8";
           end else begin mpos = mpos + d; tag = "R3"; end
         end
      2: begin
           if (grp_hit[mj]) begin
             if (mj == last) begin
               if (job_full) begin ms = 4; tag = "R7"; end
               else issue_job(last);
             end else begin mpos = mpos - 1; mj = mj + 1; tag = "R4"; end
           end else begin
             fi = lowest(mj + 1, last);
             d = (fi >= 0) ? fi - mj : last + 1 - mj;
             n = msave + d; tag = "R5";
             if (n + BLK > int'(text_len)) begin mdone = 1; ms = 0; end
             else begin mpos = n; ms = 3; end
           end
         end
      3: begin ms = 1; tag = "R5"; end
      default: if (!job_full) issue_job(last); else tag = "R7";
    endcase
  endtask

  task automatic chk(bit ok, string t, int act, int exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: got %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      ms = 0; mpos = 0; msave = 0; mj = 0; mdone = 0; mjv = 0; tag = "R1";
    end else begin
      chk(int'(fetch_addr) == mpos, {tag, " fetch_addr"}, int'(fetch_addr), mpos);
      chk(job_req == mjv, {tag, " job_req"}, int'(job_req), int'(mjv));
      chk(done == mdone, {tag, " done"}, int'(done), int'(mdone));
      if (mjv) begin
        chk(int'(job_anchor) == manc, {tag, " job_anchor"}, int'(job_anchor), manc);
        chk(int'(job_len) == mlen, {tag, " job_len"}, int'(job_len), mlen);
      end
      if (job_req) begin jobs++; last_anchor = int'(job_anchor); end
      mstep();
    end
  end

  int lf = 32'h1234_5678;
  function automatic int nextr();
    lf = (lf << 1) ^ (((lf >>> 31) & 1) != 0 ? 32'h04C1_1DB7 : 0);
    return lf;
  endfunction

  initial begin
    forever begin
      @(posedge clk); #1;
      if (full_mode) job_full = nextr()[3];
      else job_full = 1'b0;
    end
  end

  task automatic fill(byte c);
    for (int i = 0; i < 256; i++) txt[i] = c;
  endtask

  task automatic set_pat(int p, string s);
    for (int i = 0; i < s.len(); i++) pat[p][i] = byte'(s[i]);
  endtask

  task automatic go(int len, int m);
    text_len = AW'(len); win_size = WW'(m);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(posedge clk); #1; n++; end
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(fetch_addr == '0, "R1 fetch_addr", int'(fetch_addr), 0);
    chk(job_req == 1'b0, "R1 job_req", int'(job_req), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    @(posedge clk); #1 rst = 1'b0;

    // A: no hits at all, window 8
    fill("z"); set_pat(0, "abcdefgh"); npat = 1;
    go(40, 8);
    @(negedge clk);
    chk(int'(fetch_addr) == 4, "R2 first address", int'(fetch_addr), 4);
    @(negedge clk);
    chk(int'(fetch_addr) == 9, "R3 full skip", int'(fetch_addr), 9);
    wait_done();
    chk(done == 1'b1, "R8 done after scan", int'(done), 1);

    // B: one true occurrence
    jobs = 0;
    for (int i = 0; i < 8; i++) txt[13 + i] = pat[0][i];
    go(48, 8); wait_done();
    chk(jobs == 1, "R6 job count", jobs, 1);
    chk(last_anchor == 13, "R6 anchor", last_anchor, 13);

    // C: first byte broken, back-walk fails late
    jobs = 0; txt[13] = "x";
    go(48, 8); wait_done();
    chk(jobs == 0, "R5 no job on partial", jobs, 0);

    // D: repetitive text, job buffer often full
    jobs = 0; fill("a"); set_pat(0, "aaaaaaaa"); full_mode = 1;
    go(30, 8); wait_done();
    chk(jobs == 23, "R7 jobs under backpressure", jobs, 23);
    full_mode = 0;

    // E: junk in unused hit bits, window 6
    jobs = 0; fill("z"); set_pat(0, "abcdef"); junk = 1;
    for (int i = 0; i < 6; i++) begin txt[5 + i] = pat[0][i]; txt[20 + i] = pat[0][i]; end
    go(40, 6); wait_done();
    chk(jobs == 2, "R9 jobs with junk bits", jobs, 2);
    chk(last_anchor == 20, "R9 last anchor", last_anchor, 20);
    junk = 0;

    // F: widest window over two-letter text, start pulsed mid-scan
    for (int i = 0; i < 256; i++) txt[i] = (nextr()[5]) ? "a" : "b";
    for (int i = 0; i < 11; i++) pat[0][i] = txt[30 + i];
    for (int i = 0; i < 11; i++) pat[1][i] = txt[90 + i];
    npat = 2; full_mode = 1; jobs = 0;
    go(200, 11);
    repeat (6) @(posedge clk);
    #1 start = 1'b1; @(posedge clk); #1 start = 1'b0;
    wait_done();
    chk(jobs >= 2, "R6 jobs on wide window", jobs, 2);
    full_mode = 0; npat = 1;

    // G: window equal to block size
    set_pat(0, "abab"); jobs = 0;
    go(120, 4); wait_done();
    chk(done == 1'b1, "R6 single-group scan done", int'(done), 1);

    // H: text shorter than one window
    go(6, 8);
    @(negedge clk);
    chk(done == 1'b1, "R8 immediate done", int'(done), 1);

    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL R8 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule